// File: doc/BRIEF.md
# Timer Clock Prescale Selector

This block decides when a 16-bit timer advances. A 3-bit select field picks the source of a one-cycle count-enable strobe. The source can be nothing at all, which freezes the timer. It can be the system clock, either undivided or divided by 8, 64, 256 or 1024. It can also be one chosen edge direction of an external input pin. The same strobe drives a plain 16-bit up-counter that sits inside the block. The counter wraps from all-ones to zero, and it can be loaded directly from a parallel value.

All divided rates come from one free-running 10-bit prescaler. The prescaler runs on the system clock and starts from zero at reset. A divided mode strobes whenever the low bits that belong to its ratio are all zero.

The external pin passes through a two-flop synchronizer. After that it feeds a two-state level tracker with the states `PIN_LOW` and `PIN_HIGH`. The transition `PIN_LOW -> PIN_HIGH` fires on a synchronized high sample and marks a rising edge. The transition `PIN_HIGH -> PIN_LOW` fires on a synchronized low sample and marks a falling edge. The tracker follows the pin in every mode. The select field only decides whether the marked edge is used. Whatever drives the pin, including the chip's own output logic, steps the counter, so software can advance the timer one step at a time.

Top module: `tmr_clk_select`

## Requirements
- R1: While `rst_n` is low, `count_o` is 16'h0000 and `count_en_o` is 0. The prescaler resets to zero and the pin tracker resets to `PIN_LOW`.
- R2: With select code 3'b000, `count_en_o` stays 0 and `count_o` holds its value, even while the external pin toggles.
- R3: With select code 3'b001, `count_en_o` is 1 in every cycle and the counter advances once per clock.
- R4: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 divide by 8, 64, 256 and 1024. In any run of consecutive cycles whose length is a multiple of the ratio, the counter advances exactly length/ratio times, whatever the prescaler phase.
- R5: With select code 3'b111, each rising edge of `ext_pin_i` gives exactly one enable cycle, two clocks after the synchronizer first samples it. Falling edges give none.
- R6: With select code 3'b110, each falling edge of `ext_pin_i` gives exactly one enable cycle. Rising edges give none.
- R7: The pin tracker follows the pin in every mode. Selecting an edge mode while the pin already sits at its new level gives no enable.
- R8: An enable when `count_o` is 16'hFFFF sets it to 16'h0000.
- R9: When `load_i` is high, `count_o` takes `load_value_i` on the next clock, even if an enable is present in that cycle.
- R10: Without a load or an enable, `count_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 3 | Clock-select code |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| load_i | input | 1 | Direct counter load strobe |
| load_value_i | input | 16 | Value to load |
| count_en_o | output | 1 | Count-enable strobe for the current cycle |
| count_o | output | 16 | Timer counter value |

## Verification
The divided modes are checked over windows that are whole multiples of each ratio. A tap wired to the wrong prescaler bit would give twice or half the expected count. A tap that strobed on every cycle where its bits were non-zero would give far more. For the edge modes, the bench raises and lowers the pin several times. A design that swapped the two edge codes, or pulsed for more than one cycle per edge, would show the wrong step count. Further checks cover an edge mode selected after the pin has already moved, a load in a cycle that also has an enable, and the wrap at 16'hFFFF. A tracker that was only active in edge modes would then produce a spurious step. Priority the wrong way round would leave the load value plus one. A saturating counter would stay stuck at all ones.

// File: rtl/tmr_sel_pkg.sv
package tmr_sel_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_PIN_FALL = 3'd6,
        CS_PIN_RISE = 3'd7
    } clk_sel_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    localparam int N_TAPS = 4;

    // log2 of each division ratio, in select-code order (8, 64, 256, 1024)
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_sel_pkg::*;
#(
    parameter int PRE_W = tap_shift(N_TAPS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] tick_o
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // one tap per ratio: strobe when the ratio's low bits are all zero
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        localparam int SH = tap_shift(t);
        assign tick_o[t] = (pre_q[SH-1:0] == '0);
    end

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge
    import tmr_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    pin_state_e             state_q;
    pin_state_e             state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (pin_s)  state_d = PIN_HIGH;
            PIN_HIGH: if (!pin_s) state_d = PIN_LOW;
            default:  state_d = PIN_LOW;
        endcase
    end

    // outputs: an edge is a transition taken this cycle
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise_o = pin_s;
            PIN_HIGH: fall_o = !pin_s;
            default: begin
                rise_o = 1'b0;
                fall_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_value_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_value_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
    import tmr_sel_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sel_i,
    input  logic             ext_pin_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_value_i,
    output logic             count_en_o,
    output logic [CNT_W-1:0] count_o
);

    logic [N_TAPS-1:0] tick;
    logic              pin_rise;
    logic              pin_fall;
    logic              en;
    clk_sel_e          sel;

    assign sel = clk_sel_e'(sel_i);

    tmr_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_pin_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // source select
    always_comb begin
        en = 1'b0;
        unique case (sel)
            CS_STOP:     en = 1'b0;
            CS_DIV1:     en = 1'b1;
            CS_DIV8:     en = tick[0];
            CS_DIV64:    en = tick[1];
            CS_DIV256:   en = tick[2];
            CS_DIV1024:  en = tick[3];
            CS_PIN_FALL: en = pin_fall;
            CS_PIN_RISE: en = pin_rise;
            default:     en = 1'b0;
        endcase
    end

    assign count_en_o = rst_n & en;

    tmr_up_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_i        (count_en_o),
        .load_i       (load_i),
        .load_value_i (load_value_i),
        .count_o      (count_o)
    );

endmodule

// File: rtl/tmr_clk_select_chk.sv
module tmr_clk_select_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel_i,
    input logic             load_i,
    input logic [CNT_W-1:0] load_value_i,
    input logic             count_en_o,
    input logic [CNT_W-1:0] count_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !count_en_o); // R1

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd0) |-> !count_en_o); // R2

    AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd1) |-> count_en_o); // R3

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd7) && count_en_o |=> (sel_i != 3'd7) || !count_en_o); // R5

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd6) && count_en_o |=> (sel_i != 3'd6) || !count_en_o); // R6

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        count_en_o && !load_i |=> count_o == ($past(count_o) + 16'd1)); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_value_i)); // R9

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en_o && !load_i |=> $stable(count_o)); // R10

endmodule

bind tmr_clk_select tmr_clk_select_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel_i),
    .load_i       (load_i),
    .load_value_i (load_value_i),
    .count_en_o   (count_en_o),
    .count_o      (count_o)
);

// File: tb/tmr_clk_select_bench.sv
module tmr_clk_select_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sel_i = 3'd0;
    logic        ext_pin_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_value_i = 16'h0;
    logic        count_en_o;
    logic [15:0] count_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int en_seen = 0;
    bit done = 1'b0;
    logic [15:0] exp_cnt = 16'h0;

    typedef struct {
        int          due;
        logic [15:0] val;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    tmr_clk_select u_tmr_clk_select (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel_i),
        .ext_pin_i    (ext_pin_i),
        .load_i       (load_i),
        .load_value_i (load_value_i),
        .count_en_o   (count_en_o),
        .count_o      (count_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver side: expected count after n more rising edges
    task automatic push_exp(input string tag, input logic [15:0] v, input int n);
        exp_item_t it;
        it.due = cyc + n;
        it.val = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (count_en_o === 1'b1) en_seen++;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, count_o, it.val);
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 count", count_o, 16'h0);
        chk("R1 en", {15'h0, count_en_o}, 16'h0);
        rst_n = 1'b1;
        step(1);

        // R2: stop code ignores pin activity
        for (int i = 0; i < 6; i++) begin
            ext_pin_i = ~ext_pin_i;
            step(5);
        end
        chk("R2 en", {15'h0, count_en_o}, 16'h0);
        step(100);
        chk("R2 hold", count_o, exp_cnt);

        // R3: every cycle
        sel_i = 3'd1;
        #1;
        chk("R3 en", {15'h0, count_en_o}, 16'h1);
        exp_cnt = exp_cnt + 16'd10;
        push_exp("R3 rate", exp_cnt, 10);
        step(10);
        sel_i = 3'd0;
        step(3);
        chk("R10 hold after stop", count_o, exp_cnt);

        // R4: divided rates over two full periods each
        for (int c = 2; c <= 5; c++) begin
            int r;
            r = (c == 2) ? 8 : (c == 3) ? 64 : (c == 4) ? 256 : 1024;
            sel_i = c[2:0];
            exp_cnt = exp_cnt + 16'd2;
            push_exp("R4 divided rate", exp_cnt, 2 * r);
            step(2 * r);
            sel_i = 3'd0;
            step(2);
        end
        step(1);
        chk("R4 final", count_o, exp_cnt);

        // R5: rising edges only
        sel_i = 3'd7;
        en_seen = 0;
        for (int i = 0; i < 3; i++) begin
            ext_pin_i = 1'b1;
            exp_cnt = exp_cnt + 16'd1;
            push_exp("R5 rise counts", exp_cnt, 5);
            step(5);
            ext_pin_i = 1'b0;
            push_exp("R5 fall ignored", exp_cnt, 5);
            step(5);
        end
        chk("R5 single pulses", en_seen[15:0], 16'd3);

        // R6: falling edges only
        sel_i = 3'd6;
        en_seen = 0;
        for (int i = 0; i < 3; i++) begin
            ext_pin_i = 1'b1;
            push_exp("R6 rise ignored", exp_cnt, 5);
            step(5);
            ext_pin_i = 1'b0;
            exp_cnt = exp_cnt + 16'd1;
            push_exp("R6 fall counts", exp_cnt, 5);
            step(5);
        end
        chk("R6 single pulses", en_seen[15:0], 16'd3);

        // R7: tracker runs while stopped; no stale edge on mode entry
        sel_i = 3'd0;
        ext_pin_i = 1'b1;
        step(5);
        sel_i = 3'd7;
        push_exp("R7 no stale edge", exp_cnt, 6);
        step(6);
        ext_pin_i = 1'b0;
        step(5);
        ext_pin_i = 1'b1;
        exp_cnt = exp_cnt + 16'd1;
        push_exp("R7 fresh edge", exp_cnt, 5);
        step(5);

        // R9 + R8: load beats enable, then wrap
        sel_i = 3'd1;
        load_i = 1'b1;
        load_value_i = 16'hFFFE;
        push_exp("R9 load over enable", 16'hFFFE, 1);
        step(1);
        load_i = 1'b0;
        push_exp("R8 reach max", 16'hFFFF, 1);
        push_exp("R8 wrap", 16'h0000, 2);
        push_exp("R8 after wrap", 16'h0001, 3);
        step(3);

        // R9 + R10: load while stopped, then hold
        sel_i = 3'd0;
        load_i = 1'b1;
        load_value_i = 16'h1234;
        push_exp("R9 load stopped", 16'h1234, 1);
        step(1);
        load_i = 1'b0;
        push_exp("R10 hold", 16'h1234, 10);
        step(12);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule